// File: doc/BRIEF.md
# Serial Shift Unit with Edge Counter

This block is a small register-mapped serial shifter for byte transfers over a three-wire link (serial data out, serial data in, serial clock). Software loads a byte into the shift register, chooses where the shift clock and the edge count come from, and then either makes the clock edges itself or waits for an external partner to make them. Each clock transition advances a 4-bit edge counter. Sixteen transitions make one byte. When the counter wraps, the block raises an overflow flag and copies the shifted byte into a buffer register. Software reads the byte from the buffer and clears the flag by writing a one to it.

The clock source is one of five: none, a software strobe, a pulse from an external timer compare, or the synchronized external serial clock on its rising or falling edge. In the external-clock encodings the counter can follow both edges of that clock, or only the software strobe. A write-one bit inverts the outgoing serial clock, so a master can drive the link entirely from software. The two-wire wire-mode codes are accepted and drive the outputs like three-wire mode. Their start detection and clock holding are not provided.

Top module: `usi_shift_unit`

## Requirements
- R1: The wire-mode field is control bits [7:6]. While it is 00, `dout` and `sck_out` are held at 0. For any other value, `dout` equals bit 7 of the shift register and `sck_out` equals the internal clock-toggle level.
- R2: The clock select is {control[5], control[4], control[3]}. With select 000, strobes, timer pulses and external clock edges change neither the counter nor the shift register.
- R3: With select 001, each write of 1 to control bit 0 (strobe) is one transition and advances the counter by one. The shift register shifts on a strobe only when the counter value before that strobe is even.
- R4: With select 010 or 011, each cycle in which `tmr_pulse` is high is one transition. Counting and shifting follow the same rule as R3.
- R5: With select 100, the shift register shifts on each rising edge of the synchronized `sck_in`. With select 110, it shifts on each falling edge. In both cases the counter advances on every edge of `sck_in`.
- R6: With select 101 or 111, the shift register shifts on the rising (101) or falling (111) edge of `sck_in`, and the counter advances only on the software strobe.
- R7: A shift moves the register one place toward the MSB and puts the synchronized `din` into bit 0. The byte therefore leaves MSB first.
- R8: When the counter steps from 15 to 0, the overflow flag (status bit 7) is set and the buffer register takes the shift register value that results from that same edge. At no other time does the buffer change.
- R9: Any status write loads the counter from bits [3:0]. Writing 1 to status bit 7 clears the overflow flag, but a wrap in the same cycle wins. A data register write does not change the counter.
- R10: Writing 1 to control bit 1 inverts the clock-toggle level. Control bits 0 and 1 clear themselves and always read as 0. Control bits [7:3] read back as written.
- R11: The register map is: address 0 control, 1 status {overflow, 000, counter}, 2 data (shift register), 3 buffer (read only). Reads are combinational. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the addressed register |
| tmr_pulse | input | 1 | Single-cycle timer compare pulse |
| sck_in | input | 1 | External serial clock (asynchronous) |
| din | input | 1 | Serial data in (asynchronous) |
| dout | output | 1 | Serial data out |
| sck_out | output | 1 | Serial clock out, driven by the toggle bit |

## Verification
The hardest case to reach is the mixed encodings 101 and 111. There, external edges shift the register while software strobes drive the counter. The wrap, and the buffer copy it triggers, then depends on how the two streams interleave rather than on a fixed count of one edge type. The stimulus interleaves external clock toggles and strobes in random order, with a random counter preload and random data-in bits. A bench model predicts the counter, the flag and the buffer after every round. Directed cases also cover flag clearing, counter preload, and data writes that must leave the counter alone.

// File: rtl/usi_shift_unit.sv
module usi_shift_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tmr_pulse,
  input  logic          sck_in,
  input  logic          din,
  output logic          dout,
  output logic          sck_out
);
  localparam int CW = $clog2(2*DW);

  logic [1:0]    mode_q;
  logic [2:0]    sel_q;
  logic          tog_q, ovf_q;
  logic [DW-1:0] sr_q, buf_q, sr_nxt;
  logic [CW-1:0] cnt_q;
  logic [2:0]    sck_s;
  logic [1:0]    din_s;
  logic          shift_ev, cnt_ev;

  wire wr_ctl = bus_we && bus_addr == 2'd0;
  wire wr_st  = bus_we && bus_addr == 2'd1;
  wire wr_dat = bus_we && bus_addr == 2'd2;
  wire strobe = wr_ctl && bus_wdata[0];
  wire toggle = wr_ctl && bus_wdata[1];
  wire ext_r  = sck_s[1] && !sck_s[2];
  wire ext_f  = !sck_s[1] && sck_s[2];
  wire wrap   = cnt_ev && cnt_q == '1;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[6:CW], bus_wdata[2]};

  always_comb begin
    shift_ev = 1'b0;
    cnt_ev   = 1'b0;
    case (sel_q)
      3'b001:         begin cnt_ev = strobe;    shift_ev = strobe && !cnt_q[0]; end
      3'b010, 3'b011: begin cnt_ev = tmr_pulse; shift_ev = tmr_pulse && !cnt_q[0]; end
      3'b100:         begin cnt_ev = ext_r || ext_f; shift_ev = ext_r; end
      3'b110:         begin cnt_ev = ext_r || ext_f; shift_ev = ext_f; end
      3'b101:         begin cnt_ev = strobe; shift_ev = ext_r; end
      3'b111:         begin cnt_ev = strobe; shift_ev = ext_f; end
      default: ;
    endcase
  end

  assign sr_nxt = shift_ev ? {sr_q[DW-2:0], din_s[1]} : sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_s <= '0;
      din_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_in};
      din_s <= {din_s[0], din};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        mode_q <= bus_wdata[7:6];
        sel_q  <= bus_wdata[5:3];
      end
      if (toggle) tog_q <= !tog_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      buf_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      sr_q <= wr_dat ? bus_wdata : sr_nxt;
      if (wr_st)       cnt_q <= bus_wdata[CW-1:0];
      else if (cnt_ev) cnt_q <= cnt_q + 1'b1;
      if (wrap) begin
        ovf_q <= 1'b1;
        buf_q <= sr_nxt;
      end else if (wr_st && bus_wdata[7]) begin
        ovf_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata[7:0] = {mode_q, sel_q, 3'b000};
      2'd1: begin bus_rdata[7] = ovf_q; bus_rdata[CW-1:0] = cnt_q; end
      2'd2: bus_rdata = sr_q;
      default: bus_rdata = buf_q;
    endcase
  end

  assign dout    = (mode_q != 2'b00) && sr_q[DW-1];
  assign sck_out = (mode_q != 2'b00) && tog_q;

  AST_NOCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 3'b000 && !wr_st && !wr_dat) |=> ($stable(cnt_q) && $stable(sr_q))); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_st) |=> (CW'(cnt_q - $past(cnt_q)) <= CW'(1))); // R3
  AST_OVF_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(cnt_q) == '1 && ($past(wr_st) || cnt_q == '0))); // R8
  AST_BUF_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_q) |-> ovf_q); // R8
  AST_SCK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && mode_q != 2'b00 && bus_wdata[7:6] != 2'b00) |=> (sck_out != $past(sck_out))); // R10
endmodule

// File: tb/usi_shift_unit_test.sv
module usi_shift_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, bus_we = 0, tmr_pulse = 0, sck_in = 0, din = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic dout, sck_out;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_sr = 0, m_buf = 0, m_ctl = 0;
  logic [3:0] m_cnt = 0;
  logic m_ovf = 0, m_tog = 0;

  usi_shift_unit uut (.clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
                      .tmr_pulse, .sck_in, .din, .dout, .sck_out);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] msel();
    return m_ctl[5:3];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input bit sh, input bit ct);
    if (sh) m_sr = {m_sr[6:0], din};
    if (ct) begin
      if (m_cnt == 4'hF) begin m_ovf = 1; m_buf = m_sr; end
      m_cnt = m_cnt + 1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
    case (a)
      2'd0: begin
        if (d[0]) begin
          if (msel() == 3'b001) apply(!m_cnt[0], 1);
          else if (msel() == 3'b101 || msel() == 3'b111) apply(0, 1);
        end
        if (d[1]) m_tog = !m_tog;
        m_ctl = d & 8'hF8;
      end
      2'd1: begin m_cnt = d[3:0]; if (d[7]) m_ovf = 0; end
      2'd2: m_sr = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic set_din(input bit v);
    @(negedge clk); din = v; repeat (3) @(negedge clk);
  endtask

  task automatic tmr();
    @(negedge clk); tmr_pulse = 1; @(negedge clk); tmr_pulse = 0;
    if (msel()[2:1] == 2'b01) apply(!m_cnt[0], 1);
  endtask

  task automatic ext_tgl();
    @(negedge clk); sck_in = !sck_in; repeat (4) @(negedge clk);
    if (sck_in) apply(msel() == 3'b100 || msel() == 3'b101, msel() == 3'b100 || msel() == 3'b110);
    else        apply(msel() == 3'b110 || msel() == 3'b111, msel() == 3'b100 || msel() == 3'b110);
  endtask

  task automatic cmp_all(input string req);
    logic [7:0] v;
    rd(1, v); chk({req, " status"}, v, {m_ovf, 3'b000, m_cnt});
    rd(2, v); chk({req, " data"}, v, m_sr);
    rd(3, v); chk({req, " buffer"}, v, m_buf);
    chk({req, " dout"}, {7'd0, dout}, {7'd0, (m_ctl[7:6] != 0) && m_sr[7]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R11 reset register", v, 8'h00);
    end
    chk("R1 reset outputs", {6'd0, dout, sck_out}, 8'h00);

    wr(2, 8'h80);
    chk("R1 mode 00 holds dout low", {7'd0, dout}, 8'h00);
    wr(0, 8'h42);
    chk("R1 mode 01 dout is MSB", {7'd0, dout}, 8'h01);
    chk("R1 mode 01 sck_out follows toggle", {7'd0, sck_out}, 8'h01);
    wr(0, 8'h40);
    chk("R1 mode change keeps toggle", {7'd0, sck_out}, 8'h01);
    wr(0, 8'h02);
    chk("R1 mode 00 holds sck_out low", {7'd0, sck_out}, 8'h00);

    wr(0, 8'h41); tmr(); set_din(1); ext_tgl(); ext_tgl();
    rd(1, v); chk("R2 no clock leaves counter", v, 8'h00);
    rd(2, v); chk("R2 no clock leaves data", v, 8'h80);

    wr(0, 8'h48); wr(2, 8'hA5); set_din(1);
    wr(0, 8'h4B); wr(0, 8'h4B);
    rd(2, v); chk("R7 MSB-first shift with din into LSB", v, 8'h4B);
    rd(1, v); chk("R3 two strobes count two", v, 8'h02);
    for (int i = 0; i < 14; i++) wr(0, 8'h4B);
    rd(3, v); chk("R8 buffer holds shifted byte", v, 8'hFF);
    rd(1, v); chk("R8 overflow set and counter wrapped", v, 8'h80);
    chk("R10 sixteen toggles restore sck_out", {7'd0, sck_out}, 8'h00);
    rd(0, v); chk("R10 strobe and toggle read zero", v, 8'h48);
    cmp_all("R3");

    wr(1, 8'h80); rd(1, v); chk("R9 write-one clears overflow", v, 8'h00);
    wr(1, 8'h05); rd(1, v); chk("R9 counter preload", v, 8'h05);
    wr(2, 8'h3C); rd(1, v); chk("R9 data write keeps counter", v, 8'h05);

    wr(0, 8'h50); wr(1, 8'h80); wr(2, 8'($urandom));
    for (int i = 0; i < 16; i++) begin set_din(1'($urandom)); tmr(); end
    cmp_all("R4 timer pulse");

    wr(0, 8'h60); wr(1, 8'h80); wr(2, 8'($urandom));
    for (int i = 0; i < 16; i++) begin set_din(1'($urandom)); ext_tgl(); end
    cmp_all("R5 external rising");
    wr(0, 8'h70); wr(1, 8'h80); wr(2, 8'($urandom));
    for (int i = 0; i < 16; i++) begin set_din(1'($urandom)); ext_tgl(); end
    cmp_all("R5 external falling");

    wr(0, 8'h68); wr(1, 8'h80); wr(2, 8'h0F); set_din(0);
    for (int i = 0; i < 16; i++) ext_tgl();
    rd(1, v); chk("R6 external edges leave counter", v, 8'h00);
    rd(2, v); chk("R6 external rising shifts eight", v, 8'h00);
    for (int i = 0; i < 16; i++) wr(0, 8'h69);
    cmp_all("R6 strobe counter");

    for (int r = 0; r < 24; r++) begin
      logic [2:0] s;
      case ($urandom % 6)
        0: s = 3'b001; 1: s = 3'b010; 2: s = 3'b100;
        3: s = 3'b110; 4: s = 3'b101; default: s = 3'b111;
      endcase
      wr(0, {2'($urandom % 3 + 1), s, 3'b000});
      wr(1, {1'b1, 3'b000, 4'($urandom)});
      wr(2, 8'($urandom));
      for (int e = 0; e < 18; e++) begin
        set_din(1'($urandom));
        if (s == 3'b001) wr(0, {m_ctl[7:3], 3'b001});
        else if (s[2:1] == 2'b01) tmr();
        else if (s[0] && ($urandom % 2 == 0)) wr(0, {m_ctl[7:3], 3'b001});
        else ext_tgl();
      end
      cmp_all(s[2] && s[0] ? "R6 random mixed" : "R8 random overflow");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule